// File: doc/BRIEF.md
# Burst Data Prefetch Source for Bus-Master DMA Writes

This block supplies payload for a bus-master write burst out of a local block buffer held in synchronous RAM with a registered output. The RAM's read port lives outside the block. The block drives the read enable and read address, and it takes the RAM's output register back as `rd_data_i`. On the other side sits a bus-interface core that paces the burst with two strobes. The first is an attribute strobe: in that cycle the shared data bus must carry the transfer attributes. The second is a per-word advance pulse: it means the word on the bus is taken now and the following word must be on the bus in the next cycle.

The RAM needs one cycle to deliver a word. To hide that cycle, the block reads word 0 before the core asks for it. By default this prefetch happens in the attribute cycle. With `EARLY_PREFETCH` set, it happens in the cycle the start request is accepted. After that, each advance pulse reads the word that comes next and steps the pointer. Correctness rests only on the two strobes and never on a fixed sampling cycle. When the last word of the block has been taken, a one-cycle done pulse ends the transfer. Stray advance pulses are then ignored until the next start.

Top module: `dma_prefetch_src`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `rd_en_o` are low.
- R2: The read of word 0 goes out on `rd_en_o`/`rd_addr_o` (address 0) in the attribute cycle when `EARLY_PREFETCH`=0, or in the start-acceptance cycle when it is 1. Either way, word 0 is on `data_o` in the cycle of the first advance pulse.
- R3: Each advance pulse during a transfer, except the one that takes the last word, reads the following word. Read addresses climb by exactly one from 0, and in the cycle of the k-th advance pulse `data_o` carries word k-1.
- R4: In every cycle where `attr_vld_i` is high, `data_o` equals `attr_i`.
- R5: `start_i` is accepted only while `busy_o` is low, and `busy_o` is high from the next cycle on. A `start_i` during a transfer is ignored and does not restart the word sequence.
- R6: `done_o` is high for exactly one cycle, the cycle after the advance pulse that takes word WORDS-1. `busy_o` is low in that same cycle.
- R7: Advance pulses while idle issue no read and raise no done pulse.
- R8: Advance pulses may come back to back or with gaps of any length, and the word sequence on `data_o` is unaffected.
- R9: WORDS = BLOCK_BYTES/(DATA_W/8) must be a power of two of at least 2, and DATA_W must be a multiple of 8. Other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a new block transfer |
| attr_vld_i | input | 1 | Core strobe: bus must carry the attributes this cycle |
| attr_i | input | DATA_W | Transfer attribute word |
| next_i | input | 1 | Core strobe: current word taken, next one due next cycle |
| rd_en_o | output | 1 | RAM read enable |
| rd_addr_o | output | AW | RAM read word address |
| rd_data_i | input | DATA_W | RAM output register contents |
| data_o | output | DATA_W | Shared data-in bus toward the core |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the last word is taken |

## Verification
The bench builds two instances side by side, both with a 32-bit word and a 128-byte block, so each burst is 32 words. One instance uses the default attribute-cycle prefetch and the other uses early prefetch. The short block makes many complete transfers possible, so the last-word boundary, the pointer wrap back to zero and the done pulse are reached over and over. Both prefetch variants see the same mix of back-to-back and widely gapped advance pulses and are checked against one behavioural model.

// File: rtl/dma_pf_pkg.sv
package dma_pf_pkg;
   typedef enum logic [1:0] {
      PF_IDLE   = 2'd0,
      PF_ARMED  = 2'd1,
      PF_STREAM = 2'd2
   } pf_state_e;
endpackage

// File: rtl/dma_pf_ctrl.sv
module dma_pf_ctrl
   import dma_pf_pkg::*;
#(
   parameter int WORDS          = 512,
   parameter bit EARLY_PREFETCH = 1'b0,
   localparam int AW            = $clog2(WORDS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic attr_vld_i,
   input  logic next_i,
   output logic restart_o,
   output logic fetch_o,
   output logic busy_o,
   output logic done_o
);
   localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

   pf_state_e       state_q, state_d;
   logic [AW-1:0]   taken_q;
   logic            prime;
   logic            advance;
   logic            last_take;

   assign restart_o = (state_q == PF_IDLE) && start_i;
   assign advance   = (state_q == PF_STREAM) && next_i;
   assign last_take = advance && (taken_q == LAST_IDX);

   generate
      if (EARLY_PREFETCH) begin : g_early
         assign prime = restart_o;
      end else begin : g_on_attr
         assign prime = (state_q == PF_ARMED) && attr_vld_i;
      end
   endgenerate

   assign fetch_o = prime || (advance && !last_take);
   assign busy_o  = (state_q != PF_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PF_IDLE:   if (start_i)    state_d = EARLY_PREFETCH ? PF_STREAM : PF_ARMED;
         PF_ARMED:  if (attr_vld_i) state_d = PF_STREAM;
         PF_STREAM: if (last_take)  state_d = PF_IDLE;
         default:                   state_d = PF_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PF_IDLE;
         taken_q <= '0;
         done_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_o  <= last_take;
         if (restart_o)    taken_q <= '0;
         else if (advance) taken_q <= taken_q + 1'b1;
      end
   end
endmodule

// File: rtl/dma_pf_ptr.sv
module dma_pf_ptr #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart_i,
   input  logic          fetch_i,
   output logic [AW-1:0] rd_addr_o
);
   logic [AW-1:0] ptr_q;

   assign rd_addr_o = restart_i ? '0 : ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr_q <= '0;
      else if (fetch_i)   ptr_q <= rd_addr_o + 1'b1;
      else if (restart_i) ptr_q <= '0;
   end
endmodule

// File: rtl/dma_pf_mux.sv
module dma_pf_mux #(
   parameter int DATA_W = 64
) (
   input  logic              sel_attr_i,
   input  logic [DATA_W-1:0] attr_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] bus_o
);
   assign bus_o = sel_attr_i ? attr_i : word_i;
endmodule

// File: rtl/dma_prefetch_src.sv
module dma_prefetch_src #(
   parameter int  DATA_W         = 64,
   parameter int  BLOCK_BYTES    = 4096,
   parameter bit  EARLY_PREFETCH = 1'b0,
   localparam int BYTES_PER_WORD = DATA_W / 8,
   localparam int WORDS          = BLOCK_BYTES / BYTES_PER_WORD,
   localparam int AW             = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              attr_vld_i,
   input  logic [DATA_W-1:0] attr_i,
   input  logic              next_i,
   output logic              rd_en_o,
   output logic [AW-1:0]     rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              busy_o,
   output logic              done_o
);
   // R9: elaboration-time parameter checks
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if ((BLOCK_BYTES % BYTES_PER_WORD) != 0 || WORDS < 2 || (1 << AW) != WORDS) begin : g_bad_block
      $error("block must hold a power-of-two word count of at least 2");
   end

   logic restart;
   logic fetch;

   dma_pf_ctrl #(
      .WORDS          (WORDS),
      .EARLY_PREFETCH (EARLY_PREFETCH)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .attr_vld_i (attr_vld_i),
      .next_i     (next_i),
      .restart_o  (restart),
      .fetch_o    (fetch),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   dma_pf_ptr #(
      .AW (AW)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .fetch_i   (fetch),
      .rd_addr_o (rd_addr_o)
   );

   dma_pf_mux #(
      .DATA_W (DATA_W)
   ) u_mux (
      .sel_attr_i (attr_vld_i),
      .attr_i     (attr_i),
      .word_i     (rd_data_i),
      .bus_o      (data_o)
   );

   assign rd_en_o = fetch;
endmodule

// File: rtl/dma_prefetch_src_chk.sv
module dma_prefetch_src_chk #(
   parameter int AW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          next_i,
   input logic          rd_en_o,
   input logic [AW-1:0] rd_addr_o,
   input logic          busy_o,
   input logic          done_o
);
   logic [AW-1:0] prev_addr_q;
   logic          armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_addr_q <= '0;
         armed_q     <= 1'b0;
      end else begin
         if (rd_en_o) prev_addr_q <= rd_addr_o;
         if (start_i && !busy_o && !rd_en_o) armed_q <= 1'b1;
         else if (rd_en_o)                   armed_q <= 1'b0;
      end
   end

   AST_FIRST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o && (armed_q || (start_i && !busy_o))) |-> (rd_addr_o == '0)); // R2

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o && rd_addr_o != '0) |-> (rd_addr_o == prev_addr_q + 1'b1)); // R3

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R6

   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i && next_i) |-> !rd_en_o); // R7

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R5
endmodule

bind dma_prefetch_src dma_prefetch_src_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .next_i    (next_i),
   .rd_en_o   (rd_en_o),
   .rd_addr_o (rd_addr_o),
   .busy_o    (busy_o),
   .done_o    (done_o)
);

// File: tb/dma_prefetch_src_test.sv
`timescale 1ns/1ps
module dma_prefetch_src_test;
   localparam int DW = 32;
   localparam int BB = 128;
   localparam int W  = BB / (DW / 8);
   localparam int AW = $clog2(W);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          attr_vld = 1'b0;
   logic          nxt = 1'b0;
   logic [DW-1:0] attr = '0;

   logic          rd_en_a, rd_en_b, busy_a, busy_b, done_a, done_b;
   logic [AW-1:0] rd_addr_a, rd_addr_b;
   logic [DW-1:0] q_a, q_b, data_a, data_b;
   logic [DW-1:0] mem [W];

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic busy_m = 1'b0;
   logic done_m = 1'b0;
   int   taken_m = 0;

   always #2 clk = ~clk;

   dma_prefetch_src #(.DATA_W(DW), .BLOCK_BYTES(BB), .EARLY_PREFETCH(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .attr_vld_i(attr_vld), .attr_i(attr),
      .next_i(nxt), .rd_en_o(rd_en_a), .rd_addr_o(rd_addr_a), .rd_data_i(q_a),
      .data_o(data_a), .busy_o(busy_a), .done_o(done_a));

   dma_prefetch_src #(.DATA_W(DW), .BLOCK_BYTES(BB), .EARLY_PREFETCH(1'b1)) uut_early (
      .clk(clk), .rst_n(rst_n), .start_i(start), .attr_vld_i(attr_vld), .attr_i(attr),
      .next_i(nxt), .rd_en_o(rd_en_b), .rd_addr_o(rd_addr_b), .rd_data_i(q_b),
      .data_o(data_b), .busy_o(busy_b), .done_o(done_b));

   always_ff @(posedge clk) begin
      if (rd_en_a) q_a <= mem[rd_addr_a];
      if (rd_en_b) q_b <= mem[rd_addr_b];
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   task automatic cycle(input logic s, input logic av, input logic nx);
      logic done_n;
      @(negedge clk);
      start = s; attr_vld = av; nxt = nx; attr = $urandom;
      #1;
      chk("R5 busy", {31'd0, busy_a}, {31'd0, busy_m});
      chk("R5 busy early", {31'd0, busy_b}, {31'd0, busy_m});
      chk("R6 done", {31'd0, done_a}, {31'd0, done_m});
      chk("R6 done early", {31'd0, done_b}, {31'd0, done_m});
      if (av) begin
         chk("R4 attr", data_a, attr);
         chk("R4 attr early", data_b, attr);
      end
      if (nx && busy_m) begin
         chk("R3 R8 word", data_a, mem[taken_m]);
         chk("R2 R3 word early", data_b, mem[taken_m]);
      end
      if (nx && !busy_m && !s) begin
         chk("R7 no read", {31'd0, rd_en_a}, 32'd0);
         chk("R7 no read early", {31'd0, rd_en_b}, 32'd0);
      end
      done_n = busy_m && nx && (taken_m == W - 1);
      if (!busy_m && s) begin
         busy_m = 1'b1; taken_m = 0;
      end else if (busy_m && nx) begin
         if (taken_m == W - 1) busy_m = 1'b0;
         taken_m++;
      end
      done_m = done_n;
   endtask

   task automatic xfer(input int gap_max, input bit poke_start);
      for (int i = 0; i < W; i++) mem[i] = $urandom;
      cycle(1'b1, 1'b0, 1'b0);
      repeat ($urandom_range(0, 3)) cycle(1'b0, 1'b0, 1'b0);
      cycle(1'b0, 1'b1, 1'b0);
      for (int k = 0; k < W; k++) begin
         int g = (gap_max == 0) ? 0 : $urandom_range(0, gap_max);
         for (int j = 0; j < g; j++) cycle(poke_start && (k == W / 2), 1'b0, 1'b0); // R5 start ignored
         cycle(1'b0, 1'b0, 1'b1);
      end
      cycle(1'b0, 1'b0, 1'b0); // R6 done pulse observed
      cycle(1'b0, 1'b0, 1'b0);
      repeat (3) cycle(1'b0, 1'b0, 1'b1); // R7 stray pulses
      cycle(1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < W; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      chk("R1 busy", {31'd0, busy_a | busy_b}, 32'd0);
      chk("R1 done", {31'd0, done_a | done_b}, 32'd0);
      chk("R1 rd_en", {31'd0, rd_en_a | rd_en_b}, 32'd0);
      rst_n = 1'b1;
      cycle(1'b0, 1'b0, 1'b0);
      cycle(1'b0, 1'b0, 1'b1); // R7 before any transfer
      xfer(0, 1'b0);           // R8 back to back
      xfer(4, 1'b1);           // R5 start during transfer
      xfer(12, 1'b0);          // R8 long gaps
      xfer(1, 1'b1);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule